// File: doc/BRIEF.md
# CPU-Mapped Byte FIFO with Transfer Counter

This block holds a byte-wide first-in first-out buffer that a processor reaches through three 8-bit registers on a simple synchronous register bus. The bus has an address, write data, read data, a write strobe and a read strobe. One register gives status flags and a flush command. A second register is a data window: a write stores a byte and a read removes one. A third register holds a byte count for a transfer that does not use DMA. A read of that register returns the number of bytes still left to move.

A second agent moves bytes into or out of the same buffer through a plain push/pop port. The processor side wins whenever both sides ask for the same direction in the same cycle. The bus read data is combinational: it is valid while the read strobe is high, and the pop takes effect at the next clock edge.

Top module: `cpu_fifo_xfer`

## Requirements
- R1: After reset, the status register at address 31h reads 01h. Bit 0 is the empty flag, bit 1 is the full flag and bit 2 is the flush flag. Bits 7 to 3 always read 0, and writes to them have no effect. The size register at 33h reads 00h after reset.
- R2: A bus write with bit 2 set to address 31h discards every stored byte at that clock edge. Bit 2 of 31h then reads 1 for exactly one cycle and reads 0 after that.
- R3: The full flag reads 1 when 16 bytes are stored. A push attempted while full is dropped and leaves the stored bytes unchanged.
- R4: A read of the data window at 32h while the buffer is empty returns 00h and removes nothing. A later push followed by a read returns the pushed byte.
- R5: A write to 32h pushes one byte and a read of 32h pops one byte. Bytes leave in the order they entered.
- R6: A write to 33h loads the remaining-byte count. A read of 33h returns the current count and has no side effect.
- R7: The count decreases by one for each push or pop through the 32h window that is actually carried out, and it holds at 0. Peer-port traffic does not change it, and neither do dropped accesses.
- R8: When a push and a pop arrive in the same cycle and the buffer is neither full nor empty, both are carried out and the occupancy does not change. When the processor and the peer push in the same cycle, only the processor byte is stored. The same rule applies to two pops in the same cycle.
- R9: The peer port shows the oldest byte on peer_rdata, or 00h when the buffer is empty, together with the full and empty flags. A peer push or pop changes the buffer in the same way as a processor access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Register read data (combinational) |
| peer_push | input | 1 | Peer push request |
| peer_wdata | input | 8 | Peer push data |
| peer_pop | input | 1 | Peer pop request |
| peer_rdata | output | 8 | Oldest stored byte |
| peer_full | output | 1 | Buffer full |
| peer_empty | output | 1 | Buffer empty |

## Verification
The hardest case to reach from the ports is a single cycle in which the processor and the peer both act on a buffer that is partly filled. The stimulus first loads two bytes through the window. It then raises a processor write to 32h and a peer pop in the same cycle, and checks the popped byte, the unchanged flags and the byte order that follows. Dropped accesses are exercised the same way, by driving pushes into a full buffer and pops from an empty one, and reading back through the window and the count register afterwards.

// File: rtl/cfx_pkg.sv
// Shared constants and types for the CPU-mapped FIFO.
// Assumes an 8-bit register bus with the three registers at fixed offsets.
package cfx_pkg;
    localparam int BUS_W = 8;
    localparam logic [BUS_W-1:0] ADDR_CTL  = 8'h31;
    localparam logic [BUS_W-1:0] ADDR_DATA = 8'h32;
    localparam logic [BUS_W-1:0] ADDR_SIZE = 8'h33;
    localparam int CTL_EMPTY_BIT = 0;
    localparam int CTL_FULL_BIT  = 1;
    localparam int CTL_FLUSH_BIT = 2;

    // Decoded bus operation for one cycle.
    typedef struct packed {
        logic cpu_push;
        logic cpu_pop;
        logic ctl_wr;
        logic size_wr;
    } bus_op_t;
endpackage

// File: rtl/cfx_bus_decode.sv
// Register decode and read-back mux for the three-register window.
// Assumes at most one register access per cycle. A write beats a read.
module cfx_bus_decode
    import cfx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          full,
    input  logic          empty,
    input  logic [DW-1:0] head,
    input  logic [DW-1:0] remain,
    output bus_op_t       op,
    output logic          flush_req,
    output logic [DW-1:0] bus_rdata
);
    logic flush_flag;

    // Decode strobes into per-register operations.
    always_comb begin
        op.cpu_push = bus_wr && (bus_addr == ADDR_DATA);
        op.cpu_pop  = bus_rd && !bus_wr && (bus_addr == ADDR_DATA);
        op.ctl_wr   = bus_wr && (bus_addr == ADDR_CTL);
        op.size_wr  = bus_wr && (bus_addr == ADDR_SIZE);
        flush_req   = op.ctl_wr && bus_wdata[CTL_FLUSH_BIT];
    end

    // Flush flag stays visible for one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_flag <= 1'b0;
        else        flush_flag <= flush_req;
    end

    // Read-back mux; reserved bits and unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTL: begin
                bus_rdata[CTL_EMPTY_BIT] = empty;
                bus_rdata[CTL_FULL_BIT]  = full;
                bus_rdata[CTL_FLUSH_BIT] = flush_flag;
            end
            ADDR_DATA: bus_rdata = empty ? '0 : head;
            ADDR_SIZE: bus_rdata = remain;
            default:   bus_rdata = '0;
        endcase
    end

    assert_flush_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush_flag && !flush_req |=> !flush_flag);
    assert_one_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({op.cpu_push, op.cpu_pop, op.ctl_wr, op.size_wr}) <= 1);
endmodule

// File: rtl/cfx_fifo_core.sv
// Byte storage with wrap-bit pointers.
// Assumes DEPTH is a power of two. Flush overrides push and pop in the same cycle.
module cfx_fifo_core #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          flush,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, level;

    // Occupancy and flags from the pointer difference.
    always_comb begin
        level   = wr_ptr - rd_ptr;
        full    = (level == DEPTH_P);
        empty   = (level == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        head    = mem[rd_ptr[AW-1:0]];
    end

    // Pointer update; flush returns both pointers to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_P);
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> full && $stable(wr_ptr));
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !flush |=> $stable(rd_ptr));
    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    assert_both_ops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !full && !empty && push && pop && !flush |=> $stable(level));
    assert_flags_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/cfx_xfer_count.sv
// Remaining-transfer counter: loaded by the CPU, stepped per completed byte.
// Assumes a load and a step never arrive in the same cycle; the load wins if they do.
module cfx_xfer_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic [CW-1:0] remain
);
    // Load, or decrement with a floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     remain <= '0;
        else if (load)                  remain <= load_val;
        else if (step && remain != '0)  remain <= remain - 1'b1;
    end

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> remain == $past(load_val));
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && remain == '0 |=> remain == '0);
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !step |=> $stable(remain));
endmodule

// File: rtl/cpu_fifo_xfer.sv
// Top: CPU register window and peer port sharing one byte FIFO.
// Assumes the CPU has priority over the peer for the same direction in one cycle.
module cpu_fifo_xfer
    import cfx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    input  logic       peer_push,
    input  logic [7:0] peer_wdata,
    input  logic       peer_pop,
    output logic [7:0] peer_rdata,
    output logic       peer_full,
    output logic       peer_empty
);
    localparam int DW = BUS_W;

    bus_op_t       op;
    logic          flush_req, push, pop, push_ok, pop_ok, full, empty, step;
    logic [DW-1:0] push_data, head, remain;

    cfx_bus_decode #(.DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .full(full), .empty(empty),
        .head(head), .remain(remain), .op(op), .flush_req(flush_req),
        .bus_rdata(bus_rdata)
    );

    // Merge CPU and peer requests; the CPU wins the data path.
    always_comb begin
        push      = op.cpu_push || peer_push;
        push_data = op.cpu_push ? bus_wdata : peer_wdata;
        pop       = op.cpu_pop || peer_pop;
        step      = (op.cpu_push && push_ok) || (op.cpu_pop && pop_ok);
    end

    cfx_fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_core (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .flush(flush_req), .push_ok(push_ok), .pop_ok(pop_ok),
        .head(head), .full(full), .empty(empty)
    );

    cfx_xfer_count #(.CW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(op.size_wr), .load_val(bus_wdata),
        .step(step), .remain(remain)
    );

    // Peer-side view of the buffer head and flags.
    always_comb begin
        peer_rdata = empty ? '0 : head;
        peer_full  = full;
        peer_empty = empty;
    end

    assert_peer_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op.cpu_push && !op.cpu_pop && !op.size_wr |=> $stable(remain));
endmodule

// File: tb/cpu_fifo_xfer_test.sv
module cpu_fifo_xfer_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, peer_wdata = 0;
    logic bus_wr = 0, bus_rd = 0, peer_push = 0, peer_pop = 0;
    logic [7:0] bus_rdata, peer_rdata;
    logic peer_full, peer_empty;
    int checks = 0, failures = 0;
    bit done = 0;

    cpu_fifo_xfer uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        logic [7:0] d;
        rd(a, d); chk(req, d, exp);
    endtask

    task automatic flush();
        wr(8'h31, 8'h04); @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctl after reset", 8'h31, 8'h01);
        rd_chk("R1 size after reset", 8'h33, 8'h00);
        chk("R9 peer_empty after reset", peer_empty, 1);
    endtask

    task automatic t_order();
        wr(8'h32, 8'hA1); wr(8'h32, 8'hB2); wr(8'h32, 8'hC3);
        rd_chk("R5 first", 8'h32, 8'hA1);
        rd_chk("R5 second", 8'h32, 8'hB2);
        rd_chk("R5 third", 8'h32, 8'hC3);
        rd_chk("R5 empty after drain", 8'h31, 8'h01);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) wr(8'h32, 8'(i + 16));
        rd_chk("R3 full flag", 8'h31, 8'h02);
        chk("R9 peer_full", peer_full, 1);
        wr(8'h32, 8'hEE);
        peer_push = 1; peer_wdata = 8'hDD; @(negedge clk); peer_push = 0;
        for (int i = 0; i < 16; i++) rd_chk("R3 contents kept", 8'h32, 8'(i + 16));
        rd_chk("R3 empty after drain", 8'h31, 8'h01);
    endtask

    task automatic t_empty_read();
        rd_chk("R4 empty read data", 8'h32, 8'h00);
        rd_chk("R4 still empty", 8'h31, 8'h01);
        wr(8'h32, 8'h5A);
        rd_chk("R4 pointer unmoved", 8'h32, 8'h5A);
    endtask

    task automatic t_flush();
        wr(8'h32, 8'h01); wr(8'h32, 8'h02); wr(8'h32, 8'h03);
        wr(8'h31, 8'h04);
        rd_chk("R2 flush flag one cycle", 8'h31, 8'h05);
        rd_chk("R2 flush flag cleared", 8'h31, 8'h01);
        rd_chk("R2 data discarded", 8'h32, 8'h00);
        wr(8'h32, 8'h77);
        wr(8'h31, 8'hF8);
        rd_chk("R1 reserved write ignored", 8'h31, 8'h00);
        rd_chk("R1 data kept", 8'h32, 8'h77);
    endtask

    task automatic t_count();
        wr(8'h33, 8'h03);
        rd_chk("R6 size load", 8'h33, 8'h03);
        wr(8'h32, 8'h10); wr(8'h32, 8'h11);
        rd_chk("R7 dec on push", 8'h33, 8'h01);
        peer_push = 1; peer_wdata = 8'h12; @(negedge clk); peer_push = 0;
        rd_chk("R7 peer no dec", 8'h33, 8'h01);
        rd_chk("R7 pop byte", 8'h32, 8'h10);
        rd_chk("R7 dec to zero", 8'h33, 8'h00);
        rd_chk("R7 pop byte2", 8'h32, 8'h11);
        rd_chk("R7 hold zero", 8'h33, 8'h00);
        wr(8'h33, 8'h05);
        rd_chk("R7 pop byte3", 8'h32, 8'h12);
        rd_chk("R7 dec from five", 8'h33, 8'h04);
        rd_chk("R7 dropped pop", 8'h32, 8'h00);
        rd_chk("R7 no dec on drop", 8'h33, 8'h04);
    endtask

    task automatic t_simul();
        flush();
        wr(8'h32, 8'h11); wr(8'h32, 8'h22);
        bus_addr = 8'h32; bus_wdata = 8'h33; bus_wr = 1; peer_pop = 1;
        #1 chk("R8 peer sees head", peer_rdata, 8'h11);
        @(negedge clk); bus_wr = 0; peer_pop = 0;
        rd_chk("R8 flags unchanged", 8'h31, 8'h00);
        rd_chk("R8 order a", 8'h32, 8'h22);
        rd_chk("R8 order b", 8'h32, 8'h33);
        rd_chk("R8 empty", 8'h31, 8'h01);
        bus_addr = 8'h32; bus_wdata = 8'h44; bus_wr = 1;
        peer_push = 1; peer_wdata = 8'h55;
        @(negedge clk); bus_wr = 0; peer_push = 0;
        rd_chk("R8 cpu push wins", 8'h32, 8'h44);
        rd_chk("R8 peer push dropped", 8'h31, 8'h01);
    endtask

    task automatic t_peer();
        for (int i = 0; i < 3; i++) begin
            peer_push = 1; peer_wdata = 8'(8'hC0 + i); @(negedge clk);
        end
        peer_push = 0;
        chk("R9 peer not empty", peer_empty, 0);
        chk("R9 peer head", peer_rdata, 8'hC0);
        peer_pop = 1; @(negedge clk); peer_pop = 0;
        chk("R9 peer pop head", peer_rdata, 8'hC1);
        rd_chk("R9 cpu sees rest", 8'h32, 8'hC1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        t_reset(); t_order(); t_full(); t_empty_read();
        t_flush(); flush(); t_count(); t_simul(); flush(); t_peer();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule